// File: doc/BRIEF.md
# Byte-Addressed Sized Memory Behind a System-Bus Port

This block is a small byte-organised memory placed behind a single system-bus request port. A requester presents a 64-bit byte address, an access width in bits (8, 16, 32 or 64), a read/write flag and, for writes, a 64-bit data word. The block decides whether the address is inside its memory window, which starts at `0x8000_0000` and spans `DEPTH` bytes. If it is, the block converts the address into a storage index relative to that base. It then gathers or scatters the bytes in little-endian lane order. A request that cannot be served returns an error flag.

Every accepted request produces exactly one response one clock later, carrying read data and an error bit. Narrow reads come back zero-extended, so any sign extension is left to the requester. Unaligned accesses are allowed: as long as every byte touched lies inside the window, they are served in a single response. A separate byte-wide port fills the storage with initial contents after reset, which clears every byte to zero.

Top module: `membus_mem`

## Requirements
- R1: A request whose address is below `0x8000_0000` gets a response with `rsp_err`=1 and `rsp_rdata`=0, and a write of that kind changes no stored byte.
- R2: A request is served only if every byte from the address up to address+width/8-1 lies in [base, base+DEPTH-1]. Otherwise the response has `rsp_err`=1 and memory is unchanged, including for addresses close to 2^64 that would wrap.
- R3: `req_bits` values other than 8, 16, 32 and 64 give `rsp_err`=1, and a write with such a value leaves memory unchanged.
- R4: A read returns little-endian data: the byte at the request address appears in `rsp_rdata[7:0]`, and the byte at address+k appears in bits [8k+7:8k].
- R5: A write of width w stores `req_wdata[w-1:0]` with the lowest byte going to the lowest address. No other stored byte changes.
- R6: A read of width w below 64 returns `rsp_rdata` bits [63:w] as zero. A write response always carries `rsp_rdata`=0.
- R7: An unaligned access whose bytes all lie in the window is served in one response, with no error, following R4 and R5.
- R8: `req_ready` is 1 whenever reset is low. `rsp_valid` is 1 exactly in the cycle after a request is accepted (`req_valid`&`req_ready`) and 0 otherwise.
- R9: Reset clears all stored bytes to zero. A `pl_we` pulse writes `pl_byte` at storage index `pl_idx`. When a bus write touches the same byte in the same cycle, the bus write's value is kept.
- R10: The storage index equals the request address minus `0x8000_0000`, so preload index 0 is read at the base address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | 64 | Byte address |
| req_bits | input | 7 | Access width in bits |
| req_wdata | input | 64 | Store data, low bytes used |
| rsp_valid | output | 1 | Response present |
| rsp_err | output | 1 | Request could not be served |
| rsp_rdata | output | 64 | Zero-extended load data |
| pl_we | input | 1 | Preload byte strobe |
| pl_idx | input | IDXW (10) | Preload storage index |
| pl_byte | input | 8 | Preload byte value |

## Verification
The checker assumes that a requester holds a request's fields steady only within the cycle it is accepted. It also assumes `req_bits` carries a bit count rather than an encoded size, so illegal widths such as 0 or 24 are meaningful stimuli and not don't-cares. The bench drives every request and preload strobe for exactly one cycle on the falling edge. It never issues back-to-back requests without sampling the response in between, so each response can be matched to one request. It keeps a byte-level model of storage that is updated only for writes the requirements say must land, and every error case is followed by read-backs of the affected bytes.

// File: rtl/membus_pkg.sv
package membus_pkg;

    localparam int DATA_W  = 64;
    localparam int LANES   = DATA_W / 8;
    localparam int NB_W    = $clog2(LANES) + 1;
    localparam int BITS_W  = 7;

    typedef enum logic [BITS_W-1:0] {
        WIDTH_BYTE  = 7'd8,
        WIDTH_HALF  = 7'd16,
        WIDTH_WORD  = 7'd32,
        WIDTH_DWORD = 7'd64
    } width_e;

    typedef struct packed {
        logic              valid;
        logic              write;
        logic [63:0]       addr;
        logic [BITS_W-1:0] bits;
        logic [DATA_W-1:0] wdata;
    } bus_req_t;

    typedef struct packed {
        logic              valid;
        logic              err;
        logic [DATA_W-1:0] rdata;
    } bus_rsp_t;

    // Byte count for a legal width, zero for anything else.
    function automatic logic [NB_W-1:0] width_to_bytes(input logic [BITS_W-1:0] bits);
        case (bits)
            WIDTH_BYTE:  return NB_W'(1);
            WIDTH_HALF:  return NB_W'(2);
            WIDTH_WORD:  return NB_W'(4);
            WIDTH_DWORD: return NB_W'(8);
            default:     return '0;
        endcase
    endfunction

endpackage

// File: rtl/mb_decode.sv
module mb_decode
    import membus_pkg::*;
#(
    parameter logic [63:0] BASE  = 64'h8000_0000,
    parameter int          DEPTH = 1024,
    localparam int         IDXW  = $clog2(DEPTH)
) (
    input  logic [63:0]       addr,
    input  logic [BITS_W-1:0] bits,
    output logic              hit,
    output logic [IDXW-1:0]   idx,
    output logic [NB_W-1:0]   nbytes
);
    localparam logic [63:0] DEPTH64 = 64'(DEPTH);

    logic [63:0] offset;
    logic [63:0] last_start;
    logic        below_base;
    logic        past_end;

    always_comb begin
        nbytes     = width_to_bytes(bits);
        below_base = addr < BASE;
        offset     = addr - BASE;
        // Highest legal starting offset for this width.
        last_start = DEPTH64 - 64'(nbytes);
        past_end   = offset > last_start;
        hit        = (nbytes != '0) && !below_base && !past_end;
        idx        = offset[IDXW-1:0];
    end

endmodule

// File: rtl/mb_bytes.sv
module mb_bytes
    import membus_pkg::*;
#(
    parameter int  DEPTH = 1024,
    localparam int IDXW  = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [IDXW-1:0]   wr_idx,
    input  logic [NB_W-1:0]   wr_nbytes,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              pl_we,
    input  logic [IDXW-1:0]   pl_idx,
    input  logic [7:0]        pl_byte,
    input  logic [IDXW-1:0]   rd_idx,
    output logic [LANES-1:0][7:0] rd_bytes
);
    logic [7:0] store_q [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                store_q[i] <= '0;
            end
        end else begin
            if (pl_we) begin
                store_q[pl_idx] <= pl_byte;
            end
            // Bus lanes come later so they win a same-byte collision.
            for (int k = 0; k < LANES; k++) begin
                if (wr_en && (NB_W'(k) < wr_nbytes)) begin
                    store_q[wr_idx + IDXW'(k)] <= wr_data[8*k +: 8];
                end
            end
        end
    end

    for (genvar k = 0; k < LANES; k++) begin : g_rd_lane
        assign rd_bytes[k] = store_q[rd_idx + IDXW'(k)];
    end

endmodule

// File: rtl/mb_pack.sv
module mb_pack
    import membus_pkg::*;
(
    input  logic [LANES-1:0][7:0] lanes,
    input  logic [NB_W-1:0]       nbytes,
    output logic [DATA_W-1:0]     word
);
    for (genvar k = 0; k < LANES; k++) begin : g_lane
        assign word[8*k +: 8] = (NB_W'(k) < nbytes) ? lanes[k] : 8'h00;
    end

endmodule

// File: rtl/membus_mem.sv
module membus_mem
    import membus_pkg::*;
#(
    parameter logic [63:0] BASE  = 64'h8000_0000,
    parameter int          DEPTH = 1024,
    localparam int         IDXW  = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [63:0]       req_addr,
    input  logic [BITS_W-1:0] req_bits,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [DATA_W-1:0] rsp_rdata,
    input  logic              pl_we,
    input  logic [IDXW-1:0]   pl_idx,
    input  logic [7:0]        pl_byte
);
    bus_req_t req;
    bus_rsp_t rsp_q;

    logic              accept;
    logic              hit;
    logic [IDXW-1:0]   idx;
    logic [NB_W-1:0]   nbytes;
    logic [LANES-1:0][7:0] lanes;
    logic [DATA_W-1:0] load_word;

    assign req = '{valid: req_valid, write: req_write, addr: req_addr,
                   bits: req_bits, wdata: req_wdata};

    assign req_ready = !rst;
    assign accept    = req.valid && req_ready;

    mb_decode #(.BASE(BASE), .DEPTH(DEPTH)) u_decode (
        .addr   (req.addr),
        .bits   (req.bits),
        .hit    (hit),
        .idx    (idx),
        .nbytes (nbytes)
    );

    mb_bytes #(.DEPTH(DEPTH)) u_bytes (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (accept && req.write && hit),
        .wr_idx    (idx),
        .wr_nbytes (nbytes),
        .wr_data   (req.wdata),
        .pl_we     (pl_we),
        .pl_idx    (pl_idx),
        .pl_byte   (pl_byte),
        .rd_idx    (idx),
        .rd_bytes  (lanes)
    );

    mb_pack u_pack (
        .lanes  (lanes),
        .nbytes (nbytes),
        .word   (load_word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_q <= '0;
        end else begin
            rsp_q.valid <= accept;
            rsp_q.err   <= accept && !hit;
            rsp_q.rdata <= (accept && !req.write && hit) ? load_word : '0;
        end
    end

    assign rsp_valid = rsp_q.valid;
    assign rsp_err   = rsp_q.err;
    assign rsp_rdata = rsp_q.rdata;

endmodule

// File: rtl/membus_mem_chk.sv
module membus_mem_chk
    import membus_pkg::*;
#(
    parameter logic [63:0] BASE = 64'h8000_0000
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_ready,
    input logic              req_write,
    input logic [63:0]       req_addr,
    input logic [BITS_W-1:0] req_bits,
    input logic              rsp_valid,
    input logic              rsp_err,
    input logic [DATA_W-1:0] rsp_rdata
);
    a_r8_rsp_after_accept: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> rsp_valid);

    a_r8_no_spurious_rsp: assert property (@(posedge clk) disable iff (rst)
        !(req_valid && req_ready) |=> !rsp_valid);

    a_r8_ready_out_of_reset: assert property (@(posedge clk) disable iff (rst)
        req_ready);

    a_r1_below_base_err: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && (req_addr < BASE)) |=> rsp_err);

    a_r3_bad_width_err: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && req_bits != 7'd8 && req_bits != 7'd16
         && req_bits != 7'd32 && req_bits != 7'd64) |=> rsp_err);

    a_r1_err_no_data: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_err) |-> (rsp_rdata == '0));

    a_r6_byte_zext: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && !req_write && req_bits == 7'd8)
        |=> (rsp_rdata[63:8] == '0));

    a_r6_half_zext: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && !req_write && req_bits == 7'd16)
        |=> (rsp_rdata[63:16] == '0));

    a_r6_word_zext: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && !req_write && req_bits == 7'd32)
        |=> (rsp_rdata[63:32] == '0));

    a_r6_write_no_data: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && req_write) |=> (rsp_rdata == '0));

endmodule

bind membus_mem membus_mem_chk #(.BASE(BASE)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_bits  (req_bits),
    .rsp_valid (rsp_valid),
    .rsp_err   (rsp_err),
    .rsp_rdata (rsp_rdata)
);

// File: tb/membus_mem_bench.sv
module membus_mem_bench;
    localparam int          CLK_PERIOD = 10;
    localparam logic [63:0] BASE  = 64'h8000_0000;
    localparam int          DEPTH = 1024;
    localparam int          IDXW  = $clog2(DEPTH);

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [63:0] req_addr = '0;
    logic [6:0]  req_bits = '0;
    logic [63:0] req_wdata = '0;
    logic        rsp_valid;
    logic        rsp_err;
    logic [63:0] rsp_rdata;
    logic        pl_we = 1'b0;
    logic [IDXW-1:0] pl_idx = '0;
    logic [7:0]  pl_byte = '0;

    int n_checks = 0;
    int n_fail   = 0;
    logic [7:0] model [DEPTH];

    always #(CLK_PERIOD/2) clk = ~clk;

    membus_mem #(.BASE(BASE), .DEPTH(DEPTH)) u_membus_mem (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_bits(req_bits), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
        .pl_we(pl_we), .pl_idx(pl_idx), .pl_byte(pl_byte)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] model_load(input int off, input int nb);
        logic [63:0] v = '0;
        for (int k = 0; k < nb; k++) v[8*k +: 8] = model[off + k];
        return v;
    endfunction

    // One request, driven for a single cycle; response sampled one cycle later.
    task automatic bus(input logic wr, input logic [63:0] a, input logic [6:0] b,
                       input logic [63:0] d, output logic v, output logic e,
                       output logic [63:0] q);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_bits = b; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        v = rsp_valid; e = rsp_err; q = rsp_rdata;
    endtask

    task automatic load_chk(input string tag, input logic [63:0] a, input logic [6:0] b);
        logic v, e; logic [63:0] q;
        bus(1'b0, a, b, '0, v, e, q);
        chk({tag, " valid"}, 64'(v), 64'd1);
        chk({tag, " err"}, 64'(e), 64'd0);
        chk({tag, " data"}, q, model_load(int'(a - BASE), int'(b) / 8));
    endtask

    task automatic store_ok(input string tag, input logic [63:0] a, input logic [6:0] b,
                            input logic [63:0] d);
        logic v, e; logic [63:0] q;
        bus(1'b1, a, b, d, v, e, q);
        chk({tag, " err"}, 64'(e), 64'd0);
        chk({tag, " wr rdata"}, q, 64'd0);
        for (int k = 0; k < int'(b) / 8; k++) model[int'(a - BASE) + k] = d[8*k +: 8];
    endtask

    task automatic expect_err(input string tag, input logic wr, input logic [63:0] a,
                              input logic [6:0] b);
        logic v, e; logic [63:0] q;
        bus(wr, a, b, 64'hFFFF_FFFF_FFFF_FFFF, v, e, q);
        chk({tag, " valid"}, 64'(v), 64'd1);
        chk({tag, " err"}, 64'(e), 64'd1);
        chk({tag, " rdata"}, q, 64'd0);
    endtask

    task automatic t_reset();
        chk("R8 ready in reset low", 64'(req_ready), 64'd0);
        @(negedge clk); rst = 1'b0;
        @(negedge clk);
        chk("R8 idle rsp_valid", 64'(rsp_valid), 64'd0);
        chk("R8 ready after reset", 64'(req_ready), 64'd1);
        load_chk("R9 reset zero low", BASE, 7'd64);
        load_chk("R9 reset zero top", BASE + 64'(DEPTH - 8), 7'd64);
    endtask

    task automatic t_preload();
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            pl_we = 1'b1; pl_idx = IDXW'(i); pl_byte = 8'(8'h11 * (i + 1));
            model[i] = 8'(8'h11 * (i + 1));
        end
        @(negedge clk); pl_we = 1'b0;
        load_chk("R10 base maps to index 0 / R4 LE", BASE, 7'd64);
        chk("R4 lowest address in low lane", rsp_rdata, 64'h8877_6655_4433_2211);
    endtask

    task automatic t_widths();
        load_chk("R6 byte zext", BASE + 64'd7, 7'd8);
        load_chk("R6 half zext", BASE + 64'd2, 7'd16);
        load_chk("R6 word zext", BASE + 64'd4, 7'd32);
        chk("R6 word value", rsp_rdata, 64'h0000_0000_8877_6655);
    endtask

    task automatic t_stores();
        store_ok("R5 dword", BASE + 64'h40, 7'd64, 64'h0102_0304_0506_0708);
        store_ok("R5 byte",  BASE + 64'h40, 7'd8,  64'hFFFF_FFFF_FFFF_FFAA);
        store_ok("R5 half",  BASE + 64'h42, 7'd16, 64'hEEEE_EEEE_EEEE_BBCC);
        load_chk("R5 only sized bytes", BASE + 64'h40, 7'd64);
        chk("R5 merged", rsp_rdata, 64'h0102_0304_BBCC_07AA);
        store_ok("R5 word", BASE + 64'h44, 7'd32, 64'h9999_9999_DEAD_BEEF);
        load_chk("R5 word lands", BASE + 64'h40, 7'd64);
    endtask

    task automatic t_misaligned();
        store_ok("R7 misaligned dword", BASE + 64'h103, 7'd64, 64'hCAFE_F00D_1234_5678);
        load_chk("R7 span read", BASE + 64'h100, 7'd64);
        load_chk("R7 span read hi", BASE + 64'h108, 7'd64);
        load_chk("R7 misaligned word", BASE + 64'h105, 7'd32);
    endtask

    task automatic t_bounds();
        store_ok("R2 last dword ok", BASE + 64'(DEPTH - 8), 7'd64, 64'hA1A2_A3A4_A5A6_A7A8);
        load_chk("R2 last byte ok", BASE + 64'(DEPTH - 1), 7'd8);
        expect_err("R2 dword one past", 1'b1, BASE + 64'(DEPTH - 7), 7'd64);
        expect_err("R2 byte at end", 1'b0, BASE + 64'(DEPTH), 7'd8);
        expect_err("R2 wrap address", 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 7'd16);
        load_chk("R2 top unchanged", BASE + 64'(DEPTH - 8), 7'd64);
        expect_err("R1 below base read", 1'b0, BASE - 64'd1, 7'd8);
        expect_err("R1 below base write", 1'b1, 64'h0000_0000_0000_0000, 7'd64);
        load_chk("R1 base unchanged", BASE, 7'd64);
    endtask

    task automatic t_bad_width();
        expect_err("R3 width 24 write", 1'b1, BASE + 64'h40, 7'd24);
        expect_err("R3 width 0 read", 1'b0, BASE + 64'h40, 7'd0);
        expect_err("R3 width 63 write", 1'b1, BASE + 64'h40, 7'd63);
        load_chk("R3 memory unchanged", BASE + 64'h40, 7'd64);
    endtask

    task automatic t_collision();
        logic v, e; logic [63:0] q;
        @(negedge clk);
        pl_we = 1'b1; pl_idx = IDXW'(9); pl_byte = 8'hAA;
        req_valid = 1'b1; req_write = 1'b1; req_addr = BASE + 64'd9;
        req_bits = 7'd8; req_wdata = 64'h55;
        @(negedge clk);
        pl_we = 1'b0; req_valid = 1'b0; req_write = 1'b0;
        e = rsp_err;
        chk("R9 collision store err", 64'(e), 64'd0);
        model[9] = 8'h55;
        bus(1'b0, BASE + 64'd9, 7'd8, '0, v, e, q);
        chk("R9 bus write wins", q, 64'h55);
    endtask

    task automatic t_idle();
        @(negedge clk);
        @(negedge clk);
        chk("R8 no response without request", 64'(rsp_valid), 64'd0);
    endtask

    initial begin
        for (int i = 0; i < DEPTH; i++) model[i] = '0;
        t_reset();
        t_preload();
        t_widths();
        t_stores();
        t_misaligned();
        t_bounds();
        t_bad_width();
        t_collision();
        t_idle();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL R8 watchdog actual=hung expected=finished");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule